// File: doc/BRIEF.md
# External Event Timestamp Capture Unit

This block records the moment an outside signal changes level. It watches a bank of physical input pins. Each logical capture channel is routed to one of those pins through a mapping field. When the routed pin shows an enabled edge, the unit latches the seconds and nanoseconds value of a free-running time counter. The time counter itself is supplied from outside the block as an input bus.

Rising and falling edges are handled apart. Each has its own enable bit, its own pending flag and its own set of four 16-bit capture words. A flag that is set protects its captured time until the host clears the flag by writing a 1 to it. A channel-select field chooses which channel's capture words appear on the register port. A single interrupt line reports that at least one flag is pending, and only when the capture-interrupt enable is on.

Software reaches the unit through a synchronous 16-bit register port. The port takes an address, write data and a write strobe. Read data is registered.

Top module: `evt_stamp_unit`

## Requirements
- R1: Each pin passes through two synchronizing flops and then one edge-detect stage. For a pin change made between clock edges E0 and E1, the captured time is the counter value presented at edge E3, which is the value that stood two counter steps after the change.
- R2: A rising edge on the pin routed to channel N sets status bit N (address 0x4) and loads the rising capture words. A falling edge sets bit N+8 and loads the falling capture words. The two edge types never touch each other's flag or words.
- R3: The edge-enable register (address 0x3) gates capture. Bit N enables rising capture for channel N and bit N+8 enables falling capture. An edge whose enable is clear leaves both the flag and the words unchanged.
- R4: While a status bit is set, further edges of that type on that channel do not change the held capture words.
- R5: Writing 1 to a status bit clears it and writing 0 has no effect. If a clear and a new enabled edge of the same type fall in the same cycle, the new time is captured and the bit stays set.
- R6: The mapping register (address 0x2) holds one 5-bit field per channel at bits [5N+4:5N]. A field value k from 1 to 24 routes physical pin k-1 to the channel. A field value of 0 disconnects the channel, so no edge is seen.
- R7: Bits [8+] of the select register (address 0x1) choose the channel shown in the capture words. Addresses 0x8 to 0xB hold the rising seconds high, seconds low, nanoseconds high and nanoseconds low words. Addresses 0xC to 0xF hold the same four words for falling edges. The nanoseconds high word carries 14 valid bits and reads 0 above them.
- R8: The interrupt output is high exactly when bit 2 of the interrupt-enable register (address 0x0) is set and at least one status bit is set. Other bits of that register do not enable it.
- R9: After reset every register, every capture word and the interrupt output read 0.
- R10: Read data shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | NPINS | Asynchronous physical event pins |
| time_sec | input | SECW | Seconds part of the running time counter |
| time_ns | input | NSW | Nanoseconds part of the running time counter |
| reg_addr | input | AW | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| cap_irq | output | 1 | Capture-pending interrupt |

## Verification
The riskiest case is a host write of 1 to a status bit landing in the same cycle as a new enabled edge of that type. The bench provokes this by timing the clearing write to reach the register port at exactly the third clock edge after it toggles the pin, which is when detection completes. The case is judged correct only if the bit is still set afterwards and the capture words hold the new time, not the earlier one. A second overlap is a mapping change that switches the channel between pins at different levels, which produces an edge at once. The table walk absorbs that edge before each vector is scored.

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit #(
  parameter int NPINS = 24,
  parameter int NCHAN = 2,
  parameter int SECW  = 32,
  parameter int NSW   = 30,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [SECW-1:0]  time_sec,
  input  logic [NSW-1:0]   time_ns,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             cap_irq
);
  localparam int MAPW = $clog2(NPINS + 1);
  localparam int SELW = (NCHAN > 1) ? $clog2(NCHAN) : 1;
  localparam int NSHI = NSW - 16;
  localparam int SECHI = SECW - 16;
  localparam int MAPBITS = NCHAN * MAPW;

  localparam logic [AW-1:0] A_IRQEN = AW'(0);
  localparam logic [AW-1:0] A_SEL   = AW'(1);
  localparam logic [AW-1:0] A_MAP   = AW'(2);
  localparam logic [AW-1:0] A_EN    = AW'(3);
  localparam logic [AW-1:0] A_STS   = AW'(4);
  localparam logic [AW-1:0] A_RSH   = AW'(8);
  localparam logic [AW-1:0] A_RSL   = AW'(9);
  localparam logic [AW-1:0] A_RNH   = AW'(10);
  localparam logic [AW-1:0] A_RNL   = AW'(11);
  localparam logic [AW-1:0] A_FSH   = AW'(12);
  localparam logic [AW-1:0] A_FSL   = AW'(13);
  localparam logic [AW-1:0] A_FNH   = AW'(14);
  localparam logic [AW-1:0] A_FNL   = AW'(15);

  logic                 irqen_q;
  logic [SELW-1:0]      sel_q;
  logic [MAPBITS-1:0]   map_q;
  logic [NCHAN-1:0]     ren_q, fen_q;
  logic [NCHAN-1:0]     rst_q, fst_q;
  logic [NPINS-1:0]     s1_q, s2_q;
  logic [NCHAN-1:0]     prev_q, lvl;
  logic [NCHAN-1:0]     rise_fire, fall_fire, clr_r, clr_f;
  logic [NCHAN-1:0][SECW-1:0] rsec_q, fsec_q;
  logic [NCHAN-1:0][NSW-1:0]  rns_q, fns_q;

  wire sts_wr = reg_we && (reg_addr == A_STS);
  assign clr_r = sts_wr ? reg_wdata[NCHAN-1:0] : '0;
  assign clr_f = sts_wr ? reg_wdata[8 +: NCHAN] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    wire [MAPW-1:0] fld = map_q[c*MAPW +: MAPW];
    wire            hit = (fld != '0) && (fld <= MAPW'(NPINS));
    assign lvl[c] = hit ? s2_q[fld - 1'b1] : 1'b0;
    assign rise_fire[c] = lvl[c] & ~prev_q[c] & ren_q[c] & ~(rst_q[c] & ~clr_r[c]);
    assign fall_fire[c] = ~lvl[c] & prev_q[c] & fen_q[c] & ~(fst_q[c] & ~clr_f[c]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irqen_q <= 1'b0;
      sel_q   <= '0;
      map_q   <= '0;
      ren_q   <= '0;
      fen_q   <= '0;
      rst_q   <= '0;
      fst_q   <= '0;
      prev_q  <= '0;
    end else begin
      prev_q <= lvl;
      rst_q  <= (rst_q & ~clr_r) | rise_fire;
      fst_q  <= (fst_q & ~clr_f) | fall_fire;
      if (reg_we) begin
        case (reg_addr)
          A_IRQEN: irqen_q <= reg_wdata[2];
          A_SEL:   sel_q   <= reg_wdata[8 +: SELW];
          A_MAP:   map_q   <= reg_wdata[MAPBITS-1:0];
          A_EN: begin
            ren_q <= reg_wdata[NCHAN-1:0];
            fen_q <= reg_wdata[8 +: NCHAN];
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsec_q <= '0;
      fsec_q <= '0;
      rns_q  <= '0;
      fns_q  <= '0;
    end else begin
      for (int c = 0; c < NCHAN; c++) begin
        if (rise_fire[c]) begin
          rsec_q[c] <= time_sec;
          rns_q[c]  <= time_ns;
        end
        if (fall_fire[c]) begin
          fsec_q[c] <= time_sec;
          fns_q[c]  <= time_ns;
        end
      end
    end

  logic [SECW-1:0] rsec_v, fsec_v;
  logic [NSW-1:0]  rns_v, fns_v;
  logic [15:0]     rd_mux;

  always_comb begin
    rsec_v = '0;
    fsec_v = '0;
    rns_v  = '0;
    fns_v  = '0;
    for (int c = 0; c < NCHAN; c++)
      if (sel_q == SELW'(c)) begin
        rsec_v = rsec_q[c];
        fsec_v = fsec_q[c];
        rns_v  = rns_q[c];
        fns_v  = fns_q[c];
      end
  end

  always_comb begin
    case (reg_addr)
      A_IRQEN: rd_mux = {13'b0, irqen_q, 2'b0};
      A_SEL:   rd_mux = {{(8-SELW){1'b0}}, sel_q, 8'h00};
      A_MAP:   rd_mux = {{(16-MAPBITS){1'b0}}, map_q};
      A_EN:    rd_mux = {{(8-NCHAN){1'b0}}, fen_q, {(8-NCHAN){1'b0}}, ren_q};
      A_STS:   rd_mux = {{(8-NCHAN){1'b0}}, fst_q, {(8-NCHAN){1'b0}}, rst_q};
      A_RSH:   rd_mux = rsec_v[SECW-1 -: SECHI];
      A_RSL:   rd_mux = rsec_v[15:0];
      A_RNH:   rd_mux = {{(16-NSHI){1'b0}}, rns_v[NSW-1:16]};
      A_RNL:   rd_mux = rns_v[15:0];
      A_FSH:   rd_mux = fsec_v[SECW-1 -: SECHI];
      A_FSL:   rd_mux = fsec_v[15:0];
      A_FNH:   rd_mux = {{(16-NSHI){1'b0}}, fns_v[NSW-1:16]};
      A_FNL:   rd_mux = fns_v[15:0];
      default: rd_mux = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_mux;

  assign cap_irq = irqen_q & (|{rst_q, fst_q});
endmodule

// File: rtl/evt_stamp_unit_chk.sv
module evt_stamp_unit_chk #(
  parameter int NCHAN = 2,
  parameter int NSW   = 30,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [15:0]      reg_wdata,
  input logic             cap_irq,
  input logic             irqen,
  input logic [NCHAN-1:0] rst_q,
  input logic [NCHAN-1:0] fst_q,
  input logic [NCHAN-1:0] rise_fire,
  input logic [NCHAN-1:0] fen,
  input logic [NSW-1:0]   rns0,
  input logic [NSW-1:0]   fns0
);
  wire clr0 = reg_we && (reg_addr == AW'(4)) && reg_wdata[0];

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irqen |-> !cap_irq);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> ((rst_q | fst_q) != '0));

  a_r4_hold_rise0: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q[0] && !clr0) |=> $stable(rns0));

  a_r3_gate_fall0: assert property (@(posedge clk) disable iff (!rst_n)
    !fen[0] |=> $stable(fns0));

  a_r5_w1c_rise0: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0 && !rise_fire[0]) |=> !rst_q[0]);

  a_r2_flag_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    rise_fire[0] |=> rst_q[0]);
endmodule

bind evt_stamp_unit evt_stamp_unit_chk #(.NCHAN(NCHAN), .NSW(NSW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cap_irq(cap_irq), .irqen(irqen_q),
  .rst_q(rst_q), .fst_q(fst_q), .rise_fire(rise_fire), .fen(fen_q),
  .rns0(rns_q[0]), .fns0(fns_q[0])
);

// File: tb/sim_evt_stamp_unit.sv
module sim_evt_stamp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic [31:0] tcnt = '0;
  logic        ovr_en = 1'b0;
  logic [29:0] ovr_ns = '0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [31:0] tsec;
  logic [29:0] tns;
  int nchk = 0, nfail = 0;
  bit done = 0;

  assign tsec = tcnt ^ 32'hC0DE_0000;
  assign tns  = ovr_en ? ovr_ns : tcnt[29:0];

  evt_stamp_unit u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .time_sec(tsec), .time_ns(tns),
    .reg_addr(addr), .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata),
    .cap_irq(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) begin #1; tcnt <= tcnt + 1; end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // map, enables, pin, level, expected status
  localparam logic [42:0] VEC [0:9] = '{
    {5'd4,  16'h0101, 5'd3,  1'b1, 16'h0001},
    {5'd4,  16'h0101, 5'd3,  1'b0, 16'h0100},
    {5'd4,  16'h0100, 5'd3,  1'b1, 16'h0000},
    {5'd4,  16'h0100, 5'd3,  1'b0, 16'h0100},
    {5'd4,  16'h0101, 5'd7,  1'b1, 16'h0000},
    {5'd8,  16'h0101, 5'd7,  1'b0, 16'h0100},
    {5'd0,  16'h0101, 5'd7,  1'b1, 16'h0000},
    {5'd24, 16'h0101, 5'd23, 1'b1, 16'h0001},
    {5'd24, 16'h0001, 5'd23, 1'b0, 16'h0000},
    {5'd1,  16'h0101, 5'd0,  1'b1, 16'h0001}
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] tc, hold_ns;
    logic [3:0] ra [0:12] = '{4'd0,4'd1,4'd2,4'd3,4'd4,4'd8,4'd9,4'd10,4'd11,4'd12,4'd13,4'd14,4'd15};
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R9 irq after reset", irq, 0);
    for (int i = 0; i < 13; i++) begin
      rd(ra[i], d);
      check($sformatf("R9 reg %0d after reset", ra[i]), d, 0);
    end

    hold_ns = 0;
    for (int v = 0; v < 10; v++) begin
      logic [4:0] m, p; logic [15:0] en, ex; logic l;
      {m, en, p, l, ex} = VEC[v];
      wr(4'd2, {11'b0, m});
      wr(4'd3, en);
      idle(4);
      wr(4'd4, 16'hFFFF);
      @(negedge clk); tc = tcnt; pins[p] = l;
      idle(4);
      rd(4'd4, d);
      check($sformatf("R2 R3 R6 vec %0d status", v), d, ex);
      if (ex[0]) begin
        rd(4'd11, d);
        check($sformatf("R1 vec %0d rise ns", v), d, tc[15:0] + 16'd2);
        hold_ns = tc + 2;
      end
      if (ex[8]) begin
        rd(4'd15, d);
        check($sformatf("R1 vec %0d fall ns", v), d, tc[15:0] + 16'd2);
      end
    end

    check("R8 irq off while pending", irq, 0);
    wr(4'd0, 16'h0002);
    check("R8 wrong bit does not enable", irq, 0);
    wr(4'd0, 16'h0004);
    check("R8 irq on", irq, 1);

    @(negedge clk); pins[0] = 1'b0;
    idle(4);
    @(negedge clk); pins[0] = 1'b1;
    idle(4);
    rd(4'd11, d);
    check("R4 held rise ns", d, hold_ns[15:0]);
    rd(4'd4, d);
    check("R4 status both", d, 16'h0101);

    wr(4'd4, 16'h0000);
    rd(4'd4, d);
    check("R5 write 0 no effect", d, 16'h0101);
    wr(4'd4, 16'h0100);
    rd(4'd4, d);
    check("R5 clear fall only", d, 16'h0001);
    wr(4'd4, 16'h0001);
    idle(1);
    check("R8 irq drops when clear", irq, 0);

    @(negedge clk); pins[0] = 1'b0;
    idle(4);
    @(negedge clk); pins[0] = 1'b1;
    idle(4);
    @(negedge clk); pins[0] = 1'b0;
    idle(4);
    wr(4'd4, 16'h0100);
    rd(4'd4, d);
    check("R5 setup status", d, 16'h0001);
    @(negedge clk); tc = tcnt; pins[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 4'd4; wdata = 16'h0001; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(4'd4, d);
    check("R5 clear and edge same cycle status", d, 16'h0001);
    rd(4'd11, d);
    check("R5 clear and edge same cycle ns", d, tc[15:0] + 16'd2);

    wr(4'd2, 16'h00C1);
    wr(4'd3, 16'h0202);
    idle(4);
    wr(4'd4, 16'hFFFF);
    @(negedge clk); ovr_en = 1'b1; ovr_ns = 30'h3FFF_FFFF; tc = tcnt; pins[5] = 1'b1;
    idle(4);
    wr(4'd1, 16'h0100);
    rd(4'd10, d); check("R7 ch1 rise ns hi 14 bits", d, 16'h3FFF);
    rd(4'd11, d); check("R7 ch1 rise ns lo", d, 16'hFFFF);
    rd(4'd8, d);  check("R7 ch1 rise sec hi", d, 16'hC0DE);
    rd(4'd9, d);  check("R7 ch1 rise sec lo", d, tc[15:0] + 16'd2);
    rd(4'd4, d);  check("R2 ch1 status bit 1", d, 16'h0002);
    @(negedge clk); ovr_ns = 30'h2AAA_5555; pins[5] = 1'b0;
    idle(4);
    rd(4'd14, d); check("R7 ch1 fall ns hi", d, 16'h2AAA);
    rd(4'd15, d); check("R7 ch1 fall ns lo", d, 16'h5555);
    rd(4'd4, d);  check("R2 ch1 status bit 9", d, 16'h0202);
    wr(4'd1, 16'h0000);
    rd(4'd10, d); check("R7 ch0 view ns hi", d, 16'h0000);

    @(negedge clk); addr = 4'd0;
    @(negedge clk); d = rdata; addr = 4'd4;
    check("R10 irq enable after one cycle", d, 16'h0004);
    @(negedge clk); d = rdata;
    check("R10 status after one cycle", d, 16'h0202);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule